// File: doc/BRIEF.md
# Three-Phase Complementary PWM with Time-Shifted Outputs

This block drives three phases of complementary pulse-width modulation from one shared carrier counter. The carrier is either a sawtooth or a triangle, and a 16-bit period register sets its length. Each phase compares the carrier against its own compare value and drives a true pin and an inverted pin.

A per-unit shift control can move the whole output pattern in time by up to 255 carrier ticks. The shift can delay the pattern or advance it. Any part that is pushed past one end of the carrier cycle wraps around to the other end of the same cycle. Internally, a second counter runs at a fixed offset from the carrier position, modulo the cycle length, and the compare logic reads that counter.

All configuration goes into shadow registers through a simple write port. The shadow values take effect only at a carrier cycle boundary, or at any time while the unit is stopped.

Top module: `pwm_shift3`

## Requirements
- R1: Mode bit 1 selects a sawtooth carrier, which counts 0 to P-1 and has a cycle length L of P ticks. Mode bit 0 selects a triangle carrier, which runs 0 up to P and back down to 1 and has a cycle length L of 2P ticks. Here P is the period register. The true output of phase i is high when the carrier value is strictly less than compare register i.
- R2: While running, each inverted output is the exact inverse of its true output. While stopped or in reset, all six outputs are low.
- R3: The write port uses address 0 for the period, addresses 1, 2 and 3 for the compare values of phases 0, 1 and 2, and address 4 for shift control. The shift control fields are: bits 7:0 the shift amount, bit 8 the direction (1 = advance), bit 9 the shift enable, and bit 10 the mode.
- R4: Writes land in shadow registers. The running outputs change only from the next carrier cycle start. While stopped, the shadow values are copied every cycle.
- R5: With the shift enabled and direction 0, the output at tick t equals the unshifted output at tick (t - s) mod L.
- R6: With the shift enabled, direction 1 and a triangle carrier, the output at tick t equals the unshifted output at tick (t + s) mod L.
- R7: In sawtooth mode, direction 1 is ignored and the shift is applied as a delay.
- R8: With the shift disabled, or with a shift amount that is a multiple of L (including 0), the outputs equal the unshifted pattern.
- R9: A shift amount of L or more acts as the amount reduced modulo L.
- R10: The first clock edge that samples the run input high holds the carrier at tick 0. Each later edge advances the carrier by one tick. Dropping the run input returns the carrier to tick 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Run enable; low stops the unit and clears the position |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgWdata | input | 16 | Configuration write data |
| pwmHi | output | 3 | True PWM output, one bit per phase |
| pwmLo | output | 3 | Inverted PWM output, one bit per phase |

## Verification
The assertions assume that the period register never holds zero. Under that assumption the cycle length is never zero and both counters stay in range. The bench only ever programs periods from 3 to 5, and the reset value is nonzero. The assertions also take for granted that configuration writes do not disturb the active values in the middle of a cycle. The bench checks this at the pins: it rewrites the compare and shift values mid-cycle and confirms the old pattern holds until the wrap. Shift amounts are swept across zero, exact multiples of L, values past L and 255, in both directions and both carrier modes.

// File: rtl/pwmsh_pkg.sv
package pwmsh_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // copy shadows to active set, restart shifted counter
    logic step;   // advance shifted counter by one tick
  } ctlStrb_t;

  localparam int ADDR_PERIOD = 0;
  localparam int ADDR_CMP0   = 1;
endpackage

// File: rtl/pwmsh_ctrl.sv
module pwmsh_ctrl
  import pwmsh_pkg::*;
#(
  parameter int LW = 17
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          runEn,
  input  logic [LW-1:0] cycLen,
  output logic          running,
  output logic [LW-1:0] idx,
  output ctlStrb_t      strb
);

  logic atEnd;

  always_comb begin
    atEnd     = (idx == cycLen - LW'(1));
    strb.load = !runEn || (running && atEnd);
    strb.step = runEn && running && !atEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      idx     <= '0;
    end else begin
      running <= runEn;
      if (strb.load)      idx <= '0;
      else if (strb.step) idx <= idx + LW'(1);
    end
  end

  // R10: position stays inside the cycle while running
  assert_idx_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (idx < cycLen));

  // R10: a fresh start always begins at tick 0
  assert_start_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> (idx == '0));

  // R4: the last tick of a cycle is followed by tick 0
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (running && runEn && atEnd) |=> (idx == '0));

endmodule

// File: rtl/pwmsh_dp.sv
module pwmsh_dp
  import pwmsh_pkg::*;
#(
  parameter int CW = 16,
  parameter int SW = 8,
  parameter int NPH = 3,
  parameter int AW = 3,
  parameter logic [CW-1:0] RST_PERIOD = 16'd100,
  parameter int LW = CW + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgWe,
  input  logic [AW-1:0]  cfgAddr,
  input  logic [CW-1:0]  cfgWdata,
  input  ctlStrb_t       strb,
  input  logic           running,
  output logic [LW-1:0]  cycLen,
  output logic [LW-1:0]  shIdx,
  output logic [LW-1:0]  offAct,
  output logic [NPH-1:0] pwmHi,
  output logic [NPH-1:0] pwmLo
);

  localparam int ADDR_SHIFT = ADDR_CMP0 + NPH;
  localparam int BIT_DIR    = SW;
  localparam int BIT_EN     = SW + 1;
  localparam int BIT_SAW    = SW + 2;

  // shadow set
  logic [CW-1:0] perSh;
  logic [CW-1:0] cmpSh [NPH];
  logic [SW-1:0] amtSh;
  logic          dirSh, enSh, sawSh;
  // active set
  logic [CW-1:0] perAct;
  logic [CW-1:0] cmpAct [NPH];
  logic          sawAct;

  logic [LW-1:0] lenSh, redAmt, offNext, carVal;
  logic          delayDir;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perSh <= RST_PERIOD;
      amtSh <= '0;
      dirSh <= 1'b0;
      enSh  <= 1'b0;
      sawSh <= 1'b0;
      for (int i = 0; i < NPH; i++) cmpSh[i] <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == AW'(ADDR_PERIOD)) perSh <= cfgWdata;
      for (int i = 0; i < NPH; i++)
        if (cfgAddr == AW'(ADDR_CMP0 + i)) cmpSh[i] <= cfgWdata;
      if (cfgAddr == AW'(ADDR_SHIFT)) begin
        amtSh <= cfgWdata[SW-1:0];
        dirSh <= cfgWdata[BIT_DIR];
        enSh  <= cfgWdata[BIT_EN];
        sawSh <= cfgWdata[BIT_SAW];
      end
    end
  end

  // offset of the shifted counter, folded into one cycle
  always_comb begin
    lenSh    = sawSh ? {1'b0, perSh} : {perSh, 1'b0};
    redAmt   = LW'(amtSh) % lenSh;
    delayDir = !dirSh || sawSh;
    if (!enSh || redAmt == '0) offNext = '0;
    else if (delayDir)         offNext = lenSh - redAmt;
    else                       offNext = redAmt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perAct <= RST_PERIOD;
      sawAct <= 1'b0;
      offAct <= '0;
      shIdx  <= '0;
      for (int i = 0; i < NPH; i++) cmpAct[i] <= '0;
    end else if (strb.load) begin
      perAct <= perSh;
      sawAct <= sawSh;
      offAct <= offNext;
      shIdx  <= offNext;
      for (int i = 0; i < NPH; i++) cmpAct[i] <= cmpSh[i];
    end else if (strb.step) begin
      shIdx <= (shIdx == cycLen - LW'(1)) ? '0 : shIdx + LW'(1);
    end
  end

  always_comb begin
    cycLen = sawAct ? {1'b0, perAct} : {perAct, 1'b0};
    if (sawAct || shIdx <= {1'b0, perAct}) carVal = shIdx;
    else                                   carVal = cycLen - shIdx;
  end

  for (genvar g = 0; g < NPH; g++) begin : gPhase
    logic hiRaw;
    assign hiRaw    = carVal < {1'b0, cmpAct[g]};
    assign pwmHi[g] = running & hiRaw;
    assign pwmLo[g] = running & ~hiRaw;
  end

  // R1: input assumption, the period is never programmed to zero
  assert_period_nonzero_R1: assert property (@(posedge clk) disable iff (!rstN)
    perSh != '0);

  // R5: shifted counter stays inside the cycle
  assert_shidx_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (shIdx < cycLen));

  // R4: the active set does not move during a step
  assert_active_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> ($stable(perAct) && $stable(offAct) && $stable(sawAct)
                   && $stable(cmpAct[0])));

endmodule

// File: rtl/pwm_shift3.sv
module pwm_shift3
  import pwmsh_pkg::*;
#(
  parameter int CW = 16,
  parameter int SW = 8,
  parameter int NPH = 3,
  parameter int AW = 3,
  parameter logic [CW-1:0] RST_PERIOD = 16'd100
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           runEn,
  input  logic           cfgWe,
  input  logic [AW-1:0]  cfgAddr,
  input  logic [CW-1:0]  cfgWdata,
  output logic [NPH-1:0] pwmHi,
  output logic [NPH-1:0] pwmLo
);

  localparam int LW = CW + 1;

  ctlStrb_t      strb;
  logic          running;
  logic [LW-1:0] idx, cycLen, shIdx, offAct;

  pwmsh_ctrl #(.LW(LW)) uCtrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cycLen(cycLen),
    .running(running), .idx(idx), .strb(strb)
  );

  pwmsh_dp #(.CW(CW), .SW(SW), .NPH(NPH), .AW(AW), .RST_PERIOD(RST_PERIOD), .LW(LW)) uDp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .strb(strb), .running(running), .cycLen(cycLen), .shIdx(shIdx), .offAct(offAct),
    .pwmHi(pwmHi), .pwmLo(pwmLo)
  );

  // expected shifted position from the sequencer's tick and the active offset
  logic [LW:0] sumIdx, wrapIdx;
  always_comb begin
    sumIdx  = {1'b0, idx} + {1'b0, offAct};
    wrapIdx = (sumIdx >= {1'b0, cycLen}) ? sumIdx - {1'b0, cycLen} : sumIdx;
  end

  // R5: shifted counter keeps a constant offset from the carrier tick
  assert_offset_track_R5: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (wrapIdx == {1'b0, shIdx}));

  // R2: complementary pins while running
  assert_complement_R2: assert property (@(posedge clk) disable iff (!rstN)
    running |-> ((pwmHi ^ pwmLo) == '1));

  // R2: all pins low while stopped
  assert_stopped_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (pwmHi == '0 && pwmLo == '0));

endmodule

// File: tb/sim_pwm_shift3.sv
module sim_pwm_shift3;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgWdata = '0;
  logic [2:0]  pwmHi, pwmLo;

  int nTests = 0;
  int nFail = 0;
  bit done = 0;

  // bench model of the configuration
  int bP, bSaw, bEn, bDir, bAmt;
  int bCmp [3];

  always #5 clk = ~clk;

  pwm_shift3 u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .pwmHi(pwmHi), .pwmLo(pwmLo)
  );

  function automatic logic [2:0] expHi(int t);
    int len, r, x, v;
    logic [2:0] e;
    len = bSaw ? bP : 2 * bP;
    r   = bEn ? bAmt % len : 0;
    if (bDir != 0 && bSaw == 0) x = (t % len + r) % len;
    else                        x = (t % len + len - r) % len;
    v = (bSaw != 0 || x <= bP) ? x : 2 * bP - x;
    for (int i = 0; i < 3; i++) e[i] = (v < bCmp[i]);
    return e;
  endfunction

  task automatic check(string tag, logic [2:0] eHi, logic [2:0] eLo);
    nTests++;
    if (pwmHi !== eHi || pwmLo !== eLo) begin
      nFail++;
      $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, pwmHi, pwmLo, eHi, eLo);
    end
  endtask

  task automatic checkTick(string tag, int t);
    logic [2:0] e;
    e = expHi(t);
    check(tag, e, ~e);
  endtask

  task automatic writeReg(int a, int d);
    cfgWe = 1'b1;
    cfgAddr = 3'(a);
    cfgWdata = 16'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic int shiftWord(int saw, int en, int dir, int amt);
    return (saw << 10) | (en << 9) | (dir << 8) | (amt & 255);
  endfunction

  // program while stopped, then run and check ticks
  task automatic runConfig(string tag, int nTicks);
    @(negedge clk);
    runEn = 1'b0;
    writeReg(0, bP);
    for (int i = 0; i < 3; i++) writeReg(1 + i, bCmp[i]);
    writeReg(4, shiftWord(bSaw, bEn, bDir, bAmt));
    @(negedge clk);
    check("R2", 3'b000, 3'b000);     // stopped: all pins low
    runEn = 1'b1;
    for (int t = 0; t < nTicks; t++) begin
      @(negedge clk);
      checkTick(tag, t);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    string tag;
    int len;
    repeat (3) @(negedge clk);
    check("R2", 3'b000, 3'b000);     // in reset
    rstN = 1'b1;
    @(negedge clk);
    check("R2", 3'b000, 3'b000);     // after reset, stopped

    // sweep: period, mode, enable, direction, amount
    for (int p = 3; p <= 5; p++) begin
      for (int saw = 0; saw < 2; saw++) begin
        for (int en = 0; en < 2; en++) begin
          for (int dir = 0; dir < 2; dir++) begin
            for (int k = 0; k < 15; k++) begin
              bP = p; bSaw = saw; bEn = en; bDir = dir;
              bAmt = (k == 14) ? 255 : k;
              bCmp[0] = 1; bCmp[1] = p / 2 + 1; bCmp[2] = p;
              len = saw ? p : 2 * p;
              if (en == 0)                 tag = "R1";
              else if (bAmt % len == 0)    tag = "R8";
              else if (bAmt >= len)        tag = "R9";
              else if (saw && dir)         tag = "R7";
              else if (dir)                tag = "R6";
              else                         tag = "R5";
              runConfig(tag, 2 * len);
            end
          end
        end
      end
    end

    // R3 and R4: mid-cycle rewrite of compare and shift takes effect at the wrap
    bP = 4; bSaw = 0; bEn = 0; bDir = 0; bAmt = 0;
    bCmp[0] = 2; bCmp[1] = 2; bCmp[2] = 2;
    runConfig("R1", 3);              // ticks 0..2 checked, at tick 2 now
    cfgWe = 1'b1; cfgAddr = 3'd1; cfgWdata = 16'd5;
    @(negedge clk);
    checkTick("R4", 3);
    cfgAddr = 3'd4; cfgWdata = 16'(shiftWord(0, 1, 0, 3));
    @(negedge clk);
    checkTick("R4", 4);
    cfgWe = 1'b0;
    for (int t = 5; t < 8; t++) begin
      @(negedge clk);
      checkTick("R4", t);            // old set still active
    end
    bCmp[0] = 5; bEn = 1; bAmt = 3;
    for (int t = 8; t < 16; t++) begin
      @(negedge clk);
      checkTick("R3/R4", t);         // new set from the cycle start
    end

    // R10: drop run mid-cycle, then restart from tick 0
    for (int t = 16; t < 19; t++) begin
      @(negedge clk);
      checkTick("R10", t);
    end
    runEn = 1'b0;
    @(negedge clk);
    check("R2", 3'b000, 3'b000);
    runEn = 1'b1;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      checkTick("R10", t);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule